// File: doc/BRIEF.md
# Low-Power Real-Time Clock with Alarm

This block is a memory-mapped real-time clock. A free-running sub-second counter and a 32-bit seconds counter advance on a slow tick strobe, which is a single-cycle enable in the bus clock domain. A 32-bit alarm compare register raises a status flag. That flag drives a level interrupt and a wakeup output, and each of the two has its own enable bit.

The counters stay frozen after reset. Software first leaves an init state, then leaves a non-valid state. The second step also needs a fixed check word in the power-glitch register. Writes to the seconds, alarm and control registers are held in staging registers and copied into the live registers on the next slow tick. Each of the three staged registers has a busy flag, and a second write to a busy register is dropped. The status bits are write-1-to-clear.

Top module: `lp_rtc`

## Requirements
- R1: After reset, every register reads 0 and `irq`, `wake` and `busy` are low.
- R2: Reads are combinational by byte offset: 0x00 seconds, 0x04 sub-second (upper bits zero), 0x08 alarm, 0x10 control, 0x14 status, 0x18 glitch word (written directly). Any other offset reads 0.
- R3: A write to seconds, alarm or control is invisible until the next slow tick, which copies it into the live register. `busy` bit 0 (seconds), bit 1 (alarm) or bit 2 (control) is 1 from the write until that tick.
- R4: A write to a staged register while its busy bit is 1 is ignored.
- R5: The counters advance only when status bit 14 is 1 and control bit 3 (run enable) is 1. Otherwise they hold.
- R6: On a slow tick with control bits 15 and 11 both 1, status bit 15 (init left) sets.
- R7: On a slow tick with status bit 15 set, control bits 15, 14, 11 and 3 all 1, and the glitch word equal to 0x41736166, status bit 14 (valid) sets. With any other glitch word the request is ignored and bit 14 stays 0.
- R8: While running, the sub-second counter (SUB_W bits, 15 by default) increments on every tick. When it wraps from all ones to 0, the seconds counter increments.
- R9: The seconds counter wraps from 0xFFFFFFFF to 0. A staged seconds value loaded on a tick overrides the increment.
- R10: On a tick while running, seconds equal to alarm sets status bit 3. `irq` = bit 3 AND control bit 7. `wake` = bit 3 AND control bit 4.
- R11: Writing status clears at once each of bits 3, 14 and 15 that is written as 1. Bits written as 0 are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | One-cycle strobe of the slow time base |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| irq | output | 1 | Level alarm interrupt |
| wake | output | 1 | Wakeup request |
| busy | output | 3 | Staging busy: bit 0 seconds, bit 1 alarm, bit 2 control |

## Verification
The in-line assertions check on every cycle that the following change only on a slow tick: live control, status bit 15 and the alarm flag. They also check that the sub-second count holds while the block is not running, that valid status never rises without the check word, and that a busy staging register ignores a new write. Only the bench scenarios show the ordering of the start-up sequence and the carry from sub-second into seconds. The same holds for the 32-bit wrap, the separate interrupt and wakeup gating, and the write-1-to-clear behaviour together with its zero-write case.

// File: rtl/lp_rtc.sv
module lp_rtc #(
  parameter int DW    = 32,
  parameter int AW    = 5,
  parameter int SUB_W = 15,
  parameter logic [31:0] CHECK_WORD = 32'h4173_6166
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slow_tick,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq,
  output logic          wake,
  output logic [2:0]    busy
);
  localparam logic [AW-1:0] A_SEC = AW'(8'h00);
  localparam logic [AW-1:0] A_SUB = AW'(8'h04);
  localparam logic [AW-1:0] A_ALM = AW'(8'h08);
  localparam logic [AW-1:0] A_CTL = AW'(8'h10);
  localparam logic [AW-1:0] A_STS = AW'(8'h14);
  localparam logic [AW-1:0] A_GLT = AW'(8'h18);
  localparam int B_RUN = 3, B_WKE = 4, B_IRE = 7, B_NSA = 11, B_NVX = 14, B_INX = 15;
  localparam int NSTG = 3;

  logic [DW-1:0]    sec_q, alm_q, ctl_q, glt_q;
  logic [SUB_W-1:0] sub_q;
  logic             flag_alm, flag_val, flag_ini;
  logic [DW-1:0]    stg [NSTG];
  logic [NSTG-1:0]  hit;
  logic             run, ini_req, val_req;

  assign hit     = {wr_en && addr == A_CTL, wr_en && addr == A_ALM, wr_en && addr == A_SEC};
  assign run     = flag_val && ctl_q[B_RUN];
  assign ini_req = ctl_q[B_INX] && ctl_q[B_NSA];
  assign val_req = flag_ini && ini_req && ctl_q[B_NVX] && ctl_q[B_RUN] && glt_q == CHECK_WORD;
  assign irq     = flag_alm && ctl_q[B_IRE];
  assign wake    = flag_alm && ctl_q[B_WKE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0; sub_q <= '0; alm_q <= '0; ctl_q <= '0; glt_q <= '0;
      flag_alm <= 1'b0; flag_val <= 1'b0; flag_ini <= 1'b0;
      busy <= '0;
      for (int i = 0; i < NSTG; i++) stg[i] <= '0;
    end else begin
      for (int i = 0; i < NSTG; i++) begin
        if (hit[i] && !busy[i]) begin
          stg[i]  <= wdata;
          busy[i] <= 1'b1;
        end else if (slow_tick) begin
          busy[i] <= 1'b0;
        end
      end
      if (wr_en && addr == A_GLT) glt_q <= wdata;
      if (wr_en && addr == A_STS) begin
        if (wdata[3])     flag_alm <= 1'b0;
        if (wdata[B_NVX]) flag_val <= 1'b0;
        if (wdata[B_INX]) flag_ini <= 1'b0;
      end
      if (slow_tick) begin
        if (run) begin
          sub_q <= sub_q + 1'b1;
          if (&sub_q) sec_q <= sec_q + 1'b1;
          if (sec_q == alm_q) flag_alm <= 1'b1;
        end
        if (busy[0]) sec_q <= stg[0];
        if (busy[1]) alm_q <= stg[1];
        if (busy[2]) ctl_q <= stg[2];
        if (ini_req) flag_ini <= 1'b1;
        if (val_req) flag_val <= 1'b1;
      end
    end
  end

  always_comb begin
    case (addr)
      A_SEC:   rdata = sec_q;
      A_SUB:   rdata = DW'(sub_q);
      A_ALM:   rdata = alm_q;
      A_CTL:   rdata = ctl_q;
      A_STS:   rdata = {16'b0, flag_ini, flag_val, 10'b0, flag_alm, 3'b0};
      A_GLT:   rdata = glt_q;
      default: rdata = '0;
    endcase
  end

  // R3
  ctl_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctl_q) |-> $past(slow_tick));
  // R4
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy[2] && hit[2]) |=> $stable(stg[2]));
  // R5
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> $stable(sub_q));
  // R6
  ini_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_ini) |-> $past(slow_tick));
  // R7
  val_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_val) |-> $past(glt_q == CHECK_WORD));
  // R10
  alarm_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_alm) |-> $past(slow_tick && run && sec_q == alm_q));
endmodule

// File: tb/test_lp_rtc.sv
module test_lp_rtc;
  logic        clk = 1'b0, rst_n = 1'b0, slow_tick = 1'b0, wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq, wake;
  logic [2:0]  busy;

  typedef struct { int sel; logic [31:0] exp; int req; } item_t;
  item_t q[$];
  int applied = 0, bad = 0;
  bit finished = 0;

  lp_rtc #(.SUB_W(4)) i_lp_rtc (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .wake(wake), .busy(busy)
  );

  always #5 clk = ~clk;

  // monitor: sel 0 rdata, 1 irq, 2 wake, 3 busy
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.sel)
        0: act = rdata;
        1: act = {31'b0, irq};
        2: act = {31'b0, wake};
        default: act = {29'b0, busy};
      endcase
      applied++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL R%0d sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
      end
    end
  end

  task automatic expect_val(input int sel, input logic [4:0] a, input logic [31:0] e, input int req);
    item_t it;
    addr = a;
    it.sel = sel; it.exp = e; it.req = req;
    q.push_back(it);
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      slow_tick = 1'b1;
      @(posedge clk); #1;
      slow_tick = 1'b0;
      @(posedge clk); #1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    // R1 reset state
    expect_val(0, 5'h00, 32'h0, 1);
    expect_val(0, 5'h10, 32'h0, 1);
    expect_val(0, 5'h14, 32'h0, 1);
    expect_val(1, 5'h00, 32'h0, 1);
    expect_val(3, 5'h00, 32'h0, 1);
    // R5 frozen before start-up
    tick(5);
    expect_val(0, 5'h04, 32'h0, 5);
    // R3 staged control write, R4 second write dropped
    wr(5'h10, 32'h0000_8800);
    expect_val(3, 5'h00, 32'h4, 3);
    expect_val(0, 5'h10, 32'h0, 3);
    wr(5'h10, 32'h0000_FFFF);
    tick(1);
    expect_val(0, 5'h10, 32'h0000_8800, 4);
    expect_val(3, 5'h00, 32'h0, 3);
    expect_val(0, 5'h14, 32'h0, 6);
    // R6 init left on next tick
    tick(1);
    expect_val(0, 5'h14, 32'h0000_8000, 6);
    // R7 wrong check word ignored; R2 glitch readback and unmapped
    wr(5'h18, 32'h1234_5678);
    wr(5'h10, 32'h0000_C808);
    wr(5'h08, 32'h0000_0100);
    tick(3);
    expect_val(0, 5'h18, 32'h1234_5678, 2);
    expect_val(0, 5'h0C, 32'h0, 2);
    expect_val(0, 5'h14, 32'h0000_8000, 7);
    expect_val(0, 5'h04, 32'h0, 5);
    // R7 correct word
    wr(5'h18, 32'h4173_6166);
    tick(1);
    expect_val(0, 5'h14, 32'h0000_C000, 7);
    expect_val(0, 5'h04, 32'h0, 8);
    // R8 counting and carry
    tick(1);
    expect_val(0, 5'h04, 32'h1, 8);
    tick(14);
    expect_val(0, 5'h04, 32'hF, 8);
    expect_val(0, 5'h00, 32'h0, 8);
    tick(1);
    expect_val(0, 5'h04, 32'h0, 8);
    expect_val(0, 5'h00, 32'h1, 8);
    // R5 run enable cleared freezes
    wr(5'h10, 32'h0000_C800);
    tick(1);
    expect_val(0, 5'h04, 32'h1, 5);
    tick(3);
    expect_val(0, 5'h04, 32'h1, 5);
    expect_val(0, 5'h00, 32'h1, 5);
    wr(5'h10, 32'h0000_C808);
    tick(2);
    expect_val(0, 5'h04, 32'h2, 5);
    // R9 load overrides and wrap
    wr(5'h00, 32'hFFFF_FFFF);
    tick(1);
    expect_val(0, 5'h00, 32'hFFFF_FFFF, 9);
    expect_val(0, 5'h04, 32'h3, 9);
    tick(13);
    expect_val(0, 5'h00, 32'h0, 9);
    expect_val(0, 5'h04, 32'h0, 9);
    // R10 alarm flag with outputs gated off
    wr(5'h08, 32'h7);
    tick(1);
    wr(5'h00, 32'h7);
    tick(1);
    expect_val(0, 5'h14, 32'h0000_C000, 10);
    tick(1);
    expect_val(0, 5'h14, 32'h0000_C008, 10);
    expect_val(1, 5'h00, 32'h0, 10);
    expect_val(2, 5'h00, 32'h0, 10);
    // R10 interrupt only
    wr(5'h10, 32'h0000_C888);
    tick(1);
    expect_val(1, 5'h00, 32'h1, 10);
    expect_val(2, 5'h00, 32'h0, 10);
    // R10 wakeup too
    wr(5'h10, 32'h0000_C898);
    tick(1);
    expect_val(1, 5'h00, 32'h1, 10);
    expect_val(2, 5'h00, 32'h1, 10);
    // R11 zero write no effect, then clear
    wr(5'h14, 32'h0);
    expect_val(0, 5'h14, 32'h0000_C008, 11);
    wr(5'h14, 32'h8);
    expect_val(0, 5'h14, 32'h0000_C000, 11);
    expect_val(1, 5'h00, 32'h0, 11);
    expect_val(2, 5'h00, 32'h0, 11);
    @(posedge clk); #1;
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule